// File: doc/BRIEF.md
# Frequency-Domain LMS Tap Engine

This block holds the complex tap weights of a block-adaptive filter that works on transformed data. An outside transform stage hands it one block of input spectrum bins. For every bin the engine multiplies the input bin by the stored weight of that bin and streams the product out, where it goes to the inverse transform. Later the same stage returns the error spectrum of that block, one bin at a time. For each error bin the engine adds the error times the conjugated input of the same bin, scaled by a power-of-two step, to the stored weight.

Traffic alternates between two phases. In the filter phase the engine takes input bins. In the adapt phase it takes error bins. A last-bin flag on the accepted stream ends each phase. Because of this, every filtering pass reads weights that the current block's update has not yet touched, and the next block sees the full update. The input bins of a block stay in a local buffer so that they can be paired with the error bins when those arrive. An adapt-enable input freezes the weights while filtering carries on.

Top module: `fdlms_tap_engine`

## Requirements
- R1: After reset, every weight equals the initial value (default real 0x400000 = 1.0 with 22 fraction bits, imaginary 0). `y_valid_o` is low and the outputs are 0 until the first input bin is accepted.
- R2: An input bin accepted in the filter phase at bin index k gives one output two clock edges later. The output carries `y_idx_o` = k, `y_last_o` equal to the input's last flag, and Y = floor(W(k)·U(k) / 2^22) for the real and imaginary parts separately (complex product).
- R3: A real or imaginary output that falls outside the signed 16-bit range is clamped to 32767 or -32768.
- R4: An error bin accepted in the adapt phase with `adapt_en_i` high replaces W(k) with W(k) + ((conj(U(k))·D(k)) >>> `mu_shift_i`). The shift is arithmetic, so it rounds toward minus infinity, and is applied to the real and imaginary parts separately. U(k) is the input bin of the most recent filter phase. The new weight is used from the next filter phase on.
- R5: A real or imaginary weight that falls outside the signed 24-bit range is clamped to 8388607 or -8388608.
- R6: An error bin accepted while `adapt_en_i` is low leaves W(k) unchanged.
- R7: After reset the engine is in the filter phase. An accepted bin with its last flag set switches phase. Input bins offered during the adapt phase are ignored: they produce no output and do not replace the buffered spectrum. Error bins offered during the filter phase are ignored and do not change any weight.
- R8: An input bin accepted on the clock edge right after the edge on which the final error bin of a block was accepted already sees the updated weight of its bin.
- R9: The bin index starts at 0 in each phase and rises by one per accepted bin. A last flag on any bin, including one before bin N-1 (N = 128), sends the index back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mu_shift_i | input | 5 | Step size as a right-shift count |
| adapt_en_i | input | 1 | Enables weight updates |
| u_valid_i | input | 1 | Input bin strobe |
| u_last_i | input | 1 | Marks the final input bin of a block |
| u_re_i | input | 16 | Input bin, real part |
| u_im_i | input | 16 | Input bin, imaginary part |
| d_valid_i | input | 1 | Error bin strobe |
| d_last_i | input | 1 | Marks the final error bin of a block |
| d_re_i | input | 16 | Error bin, real part |
| d_im_i | input | 16 | Error bin, imaginary part |
| y_valid_o | output | 1 | Output bin strobe |
| y_last_o | output | 1 | Marks the final output bin of a block |
| y_idx_o | output | 7 | Bin index of the output |
| y_re_o | output | 16 | Output bin, real part |
| y_im_o | output | 16 | Output bin, imaginary part |

## Verification
The hardest case to reach from the ports is a weight read that lands on the same clock edge as the write of that weight. This only happens when a one-bin block turns from the adapt phase straight back to the filter phase with no idle cycle. The bench sends a single input bin, then a single error bin, then a new input bin on the very next cycle, and compares the output against a weight model that has already taken in the update. Weight and output clamping both need large products that build up, so the bench uses full-scale bins with a zero shift, clamps the weights first positive and then negative, and checks every output bin after each step.

// File: rtl/fdlms_pkg.sv
package fdlms_pkg;
  localparam int unsigned DEF_TAPS   = 64;
  localparam int unsigned DEF_SMP_W  = 16;
  localparam int unsigned DEF_WGT_W  = 24;
  localparam int unsigned DEF_FRAC   = 22;
  localparam int unsigned DEF_SHFT_W = 5;

  typedef enum logic {
    PH_FILT  = 1'b0,
    PH_ADAPT = 1'b1
  } phase_e;
endpackage

// File: rtl/fdlms_sdp_ram.sv
module fdlms_sdp_ram #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DW     = 32,
  parameter bit          BYPASS = 1'b0,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic          re_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] rd_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  generate
    if (BYPASS) begin : g_bypass
      // same-edge write wins over stale array content
      always_ff @(posedge clk_i) begin
        if (re_i) rd_q <= (we_i && (wa_i == ra_i)) ? wd_i : mem[ra_i];
      end
    end else begin : g_plain
      always_ff @(posedge clk_i) begin
        if (re_i) rd_q <= mem[ra_i];
      end
    end
  endgenerate

  assign rd_o = rd_q;
endmodule

// File: rtl/fdlms_wram.sv
module fdlms_wram #(
  parameter int unsigned         N       = 128,
  parameter int unsigned         WW      = 24,
  parameter logic signed [WW-1:0] INIT_RE = 24'sh400000,
  parameter logic signed [WW-1:0] INIT_IM = 24'sh000000,
  localparam int unsigned        AW      = $clog2(N)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 re_i,
  input  logic [AW-1:0]        ra_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        wa_i,
  input  logic signed [WW-1:0] wre_i,
  input  logic signed [WW-1:0] wim_i,
  output logic signed [WW-1:0] rre_o,
  output logic signed [WW-1:0] rim_o
);
  logic [N-1:0]    written_q;
  logic            hit_q;
  logic [2*WW-1:0] rd;

  fdlms_sdp_ram #(.DEPTH(N), .DW(2*WW), .BYPASS(1'b1)) u_mem (
    .clk_i (clk_i),
    .we_i  (we_i),
    .wa_i  (wa_i),
    .wd_i  ({wre_i, wim_i}),
    .re_i  (re_i),
    .ra_i  (ra_i),
    .rd_o  (rd)
  );

  // bins never written read back the initial weight; reset clears only this map
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q <= '0;
      hit_q     <= 1'b0;
    end else begin
      if (we_i) written_q[wa_i] <= 1'b1;
      if (re_i) hit_q <= written_q[ra_i] || (we_i && (wa_i == ra_i));
    end
  end

  assign rre_o = hit_q ? rd[2*WW-1:WW] : INIT_RE;
  assign rim_o = hit_q ? rd[WW-1:0]    : INIT_IM;
endmodule

// File: rtl/fdlms_bin_mul.sv
module fdlms_bin_mul #(
  parameter int unsigned UW   = 16,
  parameter int unsigned WW   = 24,
  parameter int unsigned FRAC = 22,
  localparam int unsigned PW  = UW + WW + 1
) (
  input  logic signed [UW-1:0] u_re_i,
  input  logic signed [UW-1:0] u_im_i,
  input  logic signed [WW-1:0] w_re_i,
  input  logic signed [WW-1:0] w_im_i,
  output logic signed [UW-1:0] y_re_o,
  output logic signed [UW-1:0] y_im_o
);
  logic signed [PW-1:0] p_re, p_im, s_re, s_im;

  function automatic logic signed [UW-1:0] clip(input logic signed [PW-1:0] x);
    if (x[PW-1:UW-1] == {(PW-UW+1){x[PW-1]}}) return x[UW-1:0];
    return x[PW-1] ? {1'b1, {(UW-1){1'b0}}} : {1'b0, {(UW-1){1'b1}}};
  endfunction

  always_comb begin
    p_re   = PW'(w_re_i) * PW'(u_re_i) - PW'(w_im_i) * PW'(u_im_i);
    p_im   = PW'(w_re_i) * PW'(u_im_i) + PW'(w_im_i) * PW'(u_re_i);
    s_re   = p_re >>> FRAC;
    s_im   = p_im >>> FRAC;
    y_re_o = clip(s_re);
    y_im_o = clip(s_im);
  end
endmodule

// File: rtl/fdlms_wupdate.sv
module fdlms_wupdate #(
  parameter int unsigned UW  = 16,
  parameter int unsigned WW  = 24,
  parameter int unsigned SHW = 5,
  localparam int unsigned GW = 2 * UW + 1,
  localparam int unsigned SW = ((GW > WW) ? GW : WW) + 1
) (
  input  logic signed [WW-1:0] w_re_i,
  input  logic signed [WW-1:0] w_im_i,
  input  logic signed [UW-1:0] u_re_i,
  input  logic signed [UW-1:0] u_im_i,
  input  logic signed [UW-1:0] d_re_i,
  input  logic signed [UW-1:0] d_im_i,
  input  logic [SHW-1:0]       sh_i,
  output logic signed [WW-1:0] w_re_o,
  output logic signed [WW-1:0] w_im_o
);
  logic signed [GW-1:0] g_re, g_im, c_re, c_im;
  logic signed [SW-1:0] a_re, a_im;

  function automatic logic signed [WW-1:0] clip(input logic signed [SW-1:0] x);
    if (x[SW-1:WW-1] == {(SW-WW+1){x[SW-1]}}) return x[WW-1:0];
    return x[SW-1] ? {1'b1, {(WW-1){1'b0}}} : {1'b0, {(WW-1){1'b1}}};
  endfunction

  always_comb begin
    // conj(U) * D
    g_re   = GW'(u_re_i) * GW'(d_re_i) + GW'(u_im_i) * GW'(d_im_i);
    g_im   = GW'(u_re_i) * GW'(d_im_i) - GW'(u_im_i) * GW'(d_re_i);
    c_re   = g_re >>> sh_i;
    c_im   = g_im >>> sh_i;
    a_re   = SW'(w_re_i) + SW'(c_re);
    a_im   = SW'(w_im_i) + SW'(c_im);
    w_re_o = clip(a_re);
    w_im_o = clip(a_im);
  end
endmodule

// File: rtl/fdlms_tap_engine.sv
module fdlms_tap_engine
  import fdlms_pkg::*;
#(
  parameter int unsigned          TAPS      = DEF_TAPS,
  parameter int unsigned          UW        = DEF_SMP_W,
  parameter int unsigned          WW        = DEF_WGT_W,
  parameter int unsigned          WFRAC     = DEF_FRAC,
  parameter int unsigned          SHW       = DEF_SHFT_W,
  parameter logic signed [WW-1:0] W_INIT_RE = 24'sh400000,
  parameter logic signed [WW-1:0] W_INIT_IM = 24'sh000000,
  localparam int unsigned         N_BINS    = 2 * TAPS,
  localparam int unsigned         AW        = $clog2(N_BINS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SHW-1:0]       mu_shift_i,
  input  logic                 adapt_en_i,
  input  logic                 u_valid_i,
  input  logic                 u_last_i,
  input  logic signed [UW-1:0] u_re_i,
  input  logic signed [UW-1:0] u_im_i,
  input  logic                 d_valid_i,
  input  logic                 d_last_i,
  input  logic signed [UW-1:0] d_re_i,
  input  logic signed [UW-1:0] d_im_i,
  output logic                 y_valid_o,
  output logic                 y_last_o,
  output logic [AW-1:0]        y_idx_o,
  output logic signed [UW-1:0] y_re_o,
  output logic signed [UW-1:0] y_im_o
);
  phase_e          phase_q;
  logic [AW-1:0]   bin_q;
  logic            ph_adapt, acc_u, acc_d, acc_last;

  logic            s1_u_vld, s1_upd, s1_last;
  logic [AW-1:0]   s1_idx;
  logic [SHW-1:0]  s1_sh;
  logic signed [UW-1:0] s1_ure, s1_uim, s1_dre, s1_dim;

  logic signed [WW-1:0] w_re, w_im, wn_re, wn_im;
  logic signed [UW-1:0] ub_re, ub_im, yc_re, yc_im;
  logic [2*UW-1:0]      ub_rd;
  logic                 w_we;

  assign ph_adapt = (phase_q == PH_ADAPT);
  assign acc_u    = u_valid_i && !ph_adapt;
  assign acc_d    = d_valid_i && ph_adapt;
  assign acc_last = (acc_u && u_last_i) || (acc_d && d_last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FILT;
      bin_q   <= '0;
    end else if (acc_u || acc_d) begin
      if (acc_last) begin
        bin_q   <= '0;
        phase_q <= ph_adapt ? PH_FILT : PH_ADAPT;
      end else begin
        bin_q   <= (bin_q == AW'(N_BINS - 1)) ? '0 : bin_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_u_vld <= 1'b0;
      s1_upd   <= 1'b0;
      s1_last  <= 1'b0;
      s1_idx   <= '0;
      s1_sh    <= '0;
      s1_ure   <= '0;
      s1_uim   <= '0;
      s1_dre   <= '0;
      s1_dim   <= '0;
    end else begin
      s1_u_vld <= acc_u;
      s1_upd   <= acc_d && adapt_en_i;
      s1_last  <= acc_last;
      s1_idx   <= bin_q;
      if (acc_u) begin
        s1_ure <= u_re_i;
        s1_uim <= u_im_i;
      end
      if (acc_d) begin
        s1_dre <= d_re_i;
        s1_dim <= d_im_i;
        s1_sh  <= mu_shift_i;
      end
    end
  end

  assign w_we = s1_upd;

  fdlms_wram #(
    .N(N_BINS), .WW(WW), .INIT_RE(W_INIT_RE), .INIT_IM(W_INIT_IM)
  ) u_wram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .re_i   (acc_u || acc_d),
    .ra_i   (bin_q),
    .we_i   (w_we),
    .wa_i   (s1_idx),
    .wre_i  (wn_re),
    .wim_i  (wn_im),
    .rre_o  (w_re),
    .rim_o  (w_im)
  );

  // input spectrum held until the matching error block arrives
  fdlms_sdp_ram #(.DEPTH(N_BINS), .DW(2*UW), .BYPASS(1'b0)) u_ubuf (
    .clk_i (clk_i),
    .we_i  (acc_u),
    .wa_i  (bin_q),
    .wd_i  ({u_re_i, u_im_i}),
    .re_i  (acc_d),
    .ra_i  (bin_q),
    .rd_o  (ub_rd)
  );
  assign ub_re = ub_rd[2*UW-1:UW];
  assign ub_im = ub_rd[UW-1:0];

  fdlms_bin_mul #(.UW(UW), .WW(WW), .FRAC(WFRAC)) u_mul (
    .u_re_i (s1_ure),
    .u_im_i (s1_uim),
    .w_re_i (w_re),
    .w_im_i (w_im),
    .y_re_o (yc_re),
    .y_im_o (yc_im)
  );

  fdlms_wupdate #(.UW(UW), .WW(WW), .SHW(SHW)) u_upd (
    .w_re_i (w_re),
    .w_im_i (w_im),
    .u_re_i (ub_re),
    .u_im_i (ub_im),
    .d_re_i (s1_dre),
    .d_im_i (s1_dim),
    .sh_i   (s1_sh),
    .w_re_o (wn_re),
    .w_im_o (wn_im)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_valid_o <= 1'b0;
      y_last_o  <= 1'b0;
      y_idx_o   <= '0;
      y_re_o    <= '0;
      y_im_o    <= '0;
    end else begin
      y_valid_o <= s1_u_vld;
      y_last_o  <= s1_u_vld && s1_last;
      if (s1_u_vld) begin
        y_idx_o <= s1_idx;
        y_re_o  <= yc_re;
        y_im_o  <= yc_im;
      end
    end
  end
endmodule

// File: rtl/fdlms_tap_engine_chk.sv
module fdlms_tap_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic u_valid_i,
  input logic d_valid_i,
  input logic adapt_en_i,
  input logic ph_adapt,
  input logic w_we,
  input logic y_valid_o
);
  AST_Y_FOLLOWS_U: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_valid_i && !ph_adapt) |=> ##1 y_valid_o);                        // R2
  AST_Y_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> $past(u_valid_i && !ph_adapt, 2));                     // R2
  AST_U_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_valid_i && ph_adapt) |=> ##1 !y_valid_o);                         // R7
  AST_D_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_i && !ph_adapt) |=> !w_we);                                 // R7
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_i && ph_adapt && !adapt_en_i) |=> !w_we);                   // R6
  AST_WE_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_we |-> $past(d_valid_i && ph_adapt && adapt_en_i));                // R4
endmodule

bind fdlms_tap_engine fdlms_tap_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .u_valid_i  (u_valid_i),
  .d_valid_i  (d_valid_i),
  .adapt_en_i (adapt_en_i),
  .ph_adapt   (ph_adapt),
  .w_we       (w_we),
  .y_valid_o  (y_valid_o)
);

// File: tb/fdlms_tap_engine_test.sv
`timescale 1ns/1ps
module fdlms_tap_engine_test;
  localparam int NB = 128;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [4:0] mu_shift_i = '0;
  logic adapt_en_i = 1'b0;
  logic u_valid_i = 1'b0, u_last_i = 1'b0;
  logic signed [15:0] u_re_i = '0, u_im_i = '0;
  logic d_valid_i = 1'b0, d_last_i = 1'b0;
  logic signed [15:0] d_re_i = '0, d_im_i = '0;
  logic y_valid_o, y_last_o;
  logic [6:0] y_idx_o;
  logic signed [15:0] y_re_o, y_im_o;

  int total = 0;
  int bad = 0;

  longint mw_re [NB];
  longint mw_im [NB];
  longint mu_re [NB];
  longint mu_im [NB];

  always #2.5 clk_i = ~clk_i;

  fdlms_tap_engine uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mu_shift_i(mu_shift_i), .adapt_en_i(adapt_en_i),
    .u_valid_i(u_valid_i), .u_last_i(u_last_i), .u_re_i(u_re_i), .u_im_i(u_im_i),
    .d_valid_i(d_valid_i), .d_last_i(d_last_i), .d_re_i(d_re_i), .d_im_i(d_im_i),
    .y_valid_o(y_valid_o), .y_last_o(y_last_o), .y_idx_o(y_idx_o),
    .y_re_o(y_re_o), .y_im_o(y_im_o)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint sat(longint v, int bits);
    longint mx = (64'sd1 <<< (bits - 1)) - 1;
    longint mn = -(64'sd1 <<< (bits - 1));
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  function automatic longint pat(int i, int seed, int mode, bit im);
    if (mode == 1) return 32000;
    if (mode == 2) return -32000;
    return longint'(((i * 73 + seed * 191 + (im ? 57 : 0)) % 6001) - 3000);
  endfunction

  // filter phase: n input bins, every output checked against the weight model
  task automatic run_u(int n, int seed, int mode, string req);
    longint ey_re [NB];
    longint ey_im [NB];
    int seen = 0;
    for (int b = 0; b < n; b++) begin
      mu_re[b] = pat(b, seed, mode, 1'b0);
      mu_im[b] = pat(b, seed, mode, 1'b1);
      ey_re[b] = sat((mw_re[b] * mu_re[b] - mw_im[b] * mu_im[b]) >>> 22, 16);
      ey_im[b] = sat((mw_re[b] * mu_im[b] + mw_im[b] * mu_re[b]) >>> 22, 16);
    end
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk_i);
      if (y_valid_o) begin
        chk(y_idx_o == 7'(seen), req, "y_idx", longint'(y_idx_o), seen);
        chk(y_last_o == (seen == n - 1), req, "y_last", longint'(y_last_o), longint'(seen == n - 1));
        chk(longint'(y_re_o) == ey_re[seen], req, "y_re", longint'(y_re_o), ey_re[seen]);
        chk(longint'(y_im_o) == ey_im[seen], req, "y_im", longint'(y_im_o), ey_im[seen]);
        seen++;
      end
      d_valid_i = 1'b0;
      d_last_i  = 1'b0;
      if (i < n) begin
        u_valid_i = 1'b1;
        u_last_i  = (i == n - 1);
        u_re_i    = 16'(mu_re[i]);
        u_im_i    = 16'(mu_im[i]);
      end else begin
        u_valid_i = 1'b0;
        u_last_i  = 1'b0;
      end
    end
    chk(seen == n, req, "output count", seen, n);
  endtask

  // adapt phase: n error bins, model weights updated alongside
  task automatic run_d(int n, int seed, int mode, bit en, int sh, int idle);
    adapt_en_i = en;
    mu_shift_i = 5'(sh);
    for (int i = 0; i < n; i++) begin
      longint dr = pat(i, seed + 7, mode, 1'b0);
      longint di = pat(i, seed + 7, mode, 1'b1);
      @(negedge clk_i);
      u_valid_i = 1'b0;
      d_valid_i = 1'b1;
      d_last_i  = (i == n - 1);
      d_re_i    = 16'(dr);
      d_im_i    = 16'(di);
      if (en) begin
        mw_re[i] = sat(mw_re[i] + ((mu_re[i] * dr + mu_im[i] * di) >>> sh), 24);
        mw_im[i] = sat(mw_im[i] + ((mu_re[i] * di - mu_im[i] * dr) >>> sh), 24);
      end
    end
    for (int i = 0; i < idle; i++) begin
      @(negedge clk_i);
      d_valid_i = 1'b0;
      d_last_i  = 1'b0;
    end
  endtask

  // R7: input bins offered while error bins are awaited must yield nothing
  task automatic t_u_ignored();
    for (int i = 0; i < 7; i++) begin
      @(negedge clk_i);
      chk(!y_valid_o, "R7", "y_valid during adapt phase", longint'(y_valid_o), 0);
      u_valid_i = (i < 5);
      u_last_i  = (i == 2);
      u_re_i    = 16'sd12345;
      u_im_i    = -16'sd9876;
    end
    u_valid_i = 1'b0;
    u_last_i  = 1'b0;
  endtask

  // R7: error bins offered in the filter phase must not touch weights (seen in next block)
  task automatic t_d_ignored();
    adapt_en_i = 1'b1;
    mu_shift_i = 5'd0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      d_valid_i = 1'b1;
      d_last_i  = (i == 4);
      d_re_i    = 16'sd30000;
      d_im_i    = -16'sd30000;
    end
    @(negedge clk_i);
    d_valid_i = 1'b0;
    d_last_i  = 1'b0;
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      mw_re[b] = 64'sd4194304;
      mw_im[b] = 0;
      mu_re[b] = 0;
      mu_im[b] = 0;
    end
    repeat (3) @(negedge clk_i);
    chk(!y_valid_o, "R1", "y_valid in reset", longint'(y_valid_o), 0);
    chk(y_re_o == 0 && y_im_o == 0, "R1", "y data in reset", longint'(y_re_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!y_valid_o, "R1", "y_valid after reset", longint'(y_valid_o), 0);

    run_u(NB, 1, 0, "R1 R2");                 // initial weights give Y = U
    run_d(NB, 2, 0, 1'b1, 8, 2);
    run_u(NB, 3, 0, "R4");                    // update visible in next block
    t_u_ignored();
    run_d(NB, 4, 0, 1'b1, 4, 2);              // uses spectrum of seed 3 block
    t_d_ignored();
    run_u(NB, 5, 0, "R7");
    run_d(NB, 6, 0, 1'b1, 9, 1);

    run_u(1, 8, 0, "R8");                     // back-to-back turnaround
    run_d(1, 9, 0, 1'b1, 2, 0);
    run_u(1, 10, 0, "R8");
    run_d(NB, 11, 0, 1'b0, 3, 2);
    run_u(NB, 12, 0, "R6");                   // frozen weights

    run_d(NB, 13, 0, 1'b1, 10, 2);
    run_u(NB, 14, 1, "R2");
    run_d(NB, 15, 1, 1'b1, 0, 2);             // weights clamp positive
    run_u(NB, 16, 2, "R3 R5");
    run_d(NB, 17, 1, 1'b1, 0, 2);             // weights clamp negative
    run_u(NB, 18, 1, "R3 R5");

    run_d(NB, 19, 0, 1'b1, 12, 2);
    run_u(10, 20, 0, "R9");                   // short block
    run_d(10, 21, 0, 1'b1, 6, 2);
    run_u(NB, 22, 0, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule